// File: doc/BRIEF.md
# Byte-Aliased General Register File

This block stores the eight 16-bit general registers of a small processor core. The core reads two operands and writes one result per cycle through indexed ports. A size select on each port chooses between a full word and a single byte. In byte mode only the first four registers are reachable, and each of them splits into a low and a high half. A second write path stores a 32-bit multiply or divide result across the data and accumulator registers in one cycle. Address generation logic gets the stack pointer and the two index registers on dedicated outputs, so it never has to use an operand read port.

Reads are combinational. Writes take effect at the rising clock edge. The stack pointer comes out of reset holding the empty-stack value, and its lowest bit is held at zero at all times.

Top module: `gpr_bank`

## Requirements
- R1: After reset, registers 0 to 6 read as 0000h, and register 7 (the stack pointer) reads as FFFEh on both the read ports and `sp_out`.
- R2: In word mode the index selects, in order 0 to 7, the accumulator, base, count, data, source index, destination index, base pointer and stack pointer. A word write is visible on both read ports from the cycle after the clock edge.
- R3: In byte mode, index values 0 to 3 select the low byte of registers 0 to 3, and index values 4 to 7 select the high byte of registers 0 to 3.
- R4: A byte write changes only the selected half. The other half of the same register keeps its value.
- R5: A byte read returns the byte in bits 7:0 of the read port, with bits 15:8 at zero.
- R6: No byte-mode access reads or changes registers 4 to 7.
- R7: A pair write stores bits 31:16 in the data register and bits 15:0 in the accumulator on the same edge. On those two registers it takes priority over a port write in the same cycle. A port write to any other register in the same cycle still takes effect.
- R8: Bit 0 of the stack pointer is always 0. A word write to register 7 stores the written value with bit 0 cleared.
- R9: When a read and a write address the same register in the same cycle, the read returns the value held before the edge.
- R10: `sp_out`, `si_out` and `di_out` always show registers 7, 4 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_a_idx | input | 3 | Read port A register index |
| rd_a_byte | input | 1 | Read port A byte mode (1) or word mode (0) |
| rd_a_data | output | 16 | Read port A data |
| rd_b_idx | input | 3 | Read port B register index |
| rd_b_byte | input | 1 | Read port B byte mode (1) or word mode (0) |
| rd_b_data | output | 16 | Read port B data |
| wr_en | input | 1 | Write port enable |
| wr_idx | input | 3 | Write port register index |
| wr_byte | input | 1 | Write port byte mode (1) or word mode (0) |
| wr_data | input | 16 | Write data; bits 7:0 are used in byte mode |
| pair_wr_en | input | 1 | 32-bit pair write enable |
| pair_wr_data | input | 32 | Pair write data: upper half to the data register, lower half to the accumulator |
| sp_out | output | 16 | Stack pointer value |
| si_out | output | 16 | Source index value |
| di_out | output | 16 | Destination index value |

## Verification
The case that is hardest to reach from the ports is a collision on one edge. A pair write lands on the accumulator and data registers while the single write port is also active. The port write either targets one of those same registers or a word-only register. The bench drives both paths in the same cycle, once with the port aimed at the data register and once at the source index. Then it reads all three registers back. The read-before-write case needs a sample taken inside the write cycle, before the edge, so the bench checks port A there and again just after the edge.

// File: rtl/gpr_pkg.sv
// Shared constants for the general register file.
// Assumes exactly eight registers; the byte-index encoding depends on it.
package gpr_pkg;
    localparam int NUM_REGS  = 8;
    localparam int IDX_W     = $clog2(NUM_REGS);
    localparam int SPLIT_CNT = NUM_REGS / 2;   // registers with byte halves

    localparam int IDX_ACC  = 0;
    localparam int IDX_BASE = 1;
    localparam int IDX_CNT  = 2;
    localparam int IDX_DATA = 3;
    localparam int IDX_SRC  = 4;
    localparam int IDX_DST  = 5;
    localparam int IDX_FRM  = 6;
    localparam int IDX_STK  = 7;
endpackage

// File: rtl/gpr_cell.sv
// One register with independent low/high byte write enables.
// Assumes the write controller never asserts an enable during reset.
// FORCE_EVEN clears bit 0 on every write, for the stack pointer.
module gpr_cell #(
    parameter int          WORD_W     = 16,
    parameter logic [WORD_W-1:0] RST_VAL = '0,
    parameter bit          FORCE_EVEN = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lo_we,
    input  logic                 hi_we,
    input  logic [WORD_W/2-1:0]  lo_d,
    input  logic [WORD_W/2-1:0]  hi_d,
    output logic [WORD_W-1:0]    q
);
    localparam int BYTE_W = WORD_W / 2;

    logic [BYTE_W-1:0] lo_in;

    // Clear bit 0 of incoming low-byte data when the register must stay even.
    always_comb begin
        lo_in = lo_d;
        if (FORCE_EVEN) lo_in[0] = 1'b0;
    end

    // Store each byte half under its own enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RST_VAL;
        end else begin
            if (lo_we) q[BYTE_W-1:0]      <= lo_in;
            if (hi_we) q[WORD_W-1:BYTE_W] <= hi_d;
        end
    end
endmodule

// File: rtl/gpr_wr_ctrl.sv
// Turns the indexed write port and the 32-bit pair path into per-register
// byte enables and byte data. The pair path wins on the accumulator and the
// data register. Byte mode reaches only the first SPLIT_CNT registers.
module gpr_wr_ctrl
    import gpr_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic                                wr_en,
    input  logic [IDX_W-1:0]                    wr_idx,
    input  logic                                wr_byte,
    input  logic [WORD_W-1:0]                   wr_data,
    input  logic                                pair_wr_en,
    input  logic [2*WORD_W-1:0]                 pair_wr_data,
    output logic [NUM_REGS-1:0]                 lo_we,
    output logic [NUM_REGS-1:0]                 hi_we,
    output logic [NUM_REGS-1:0][WORD_W/2-1:0]   lo_d,
    output logic [NUM_REGS-1:0][WORD_W/2-1:0]   hi_d
);
    localparam int BYTE_W = WORD_W / 2;

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        logic word_hit, lo_hit, hi_hit, pair_hit;
        logic [WORD_W-1:0] pair_word;

        // Decode which halves of register r the write port targets.
        always_comb begin
            word_hit = wr_en && !wr_byte && (wr_idx == IDX_W'(r));
            lo_hit   = 1'b0;
            hi_hit   = 1'b0;
            if (r < SPLIT_CNT) begin
                lo_hit = wr_en && wr_byte && (wr_idx == IDX_W'(r));
                hi_hit = wr_en && wr_byte && (wr_idx == IDX_W'(r + SPLIT_CNT));
            end
        end

        // Pick the pair-path half that belongs to register r, if any.
        always_comb begin
            pair_hit  = 1'b0;
            pair_word = '0;
            if (r == IDX_ACC) begin
                pair_hit  = pair_wr_en;
                pair_word = pair_wr_data[WORD_W-1:0];
            end else if (r == IDX_DATA) begin
                pair_hit  = pair_wr_en;
                pair_word = pair_wr_data[2*WORD_W-1:WORD_W];
            end
        end

        // Merge both sources, pair path first, into enables and byte data.
        always_comb begin
            if (pair_hit) begin
                lo_we[r] = 1'b1;
                hi_we[r] = 1'b1;
                lo_d[r]  = pair_word[BYTE_W-1:0];
                hi_d[r]  = pair_word[WORD_W-1:BYTE_W];
            end else begin
                lo_we[r] = word_hit || lo_hit;
                hi_we[r] = word_hit || hi_hit;
                lo_d[r]  = wr_data[BYTE_W-1:0];
                hi_d[r]  = word_hit ? wr_data[WORD_W-1:BYTE_W] : wr_data[BYTE_W-1:0];
            end
        end
    end
endmodule

// File: rtl/gpr_rd_port.sv
// One combinational read port. Word mode returns the indexed register.
// Byte mode uses the low index bits to pick one of the splittable registers,
// uses the top index bit to pick the half, and zero-extends the result.
module gpr_rd_port
    import gpr_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic [NUM_REGS-1:0][WORD_W-1:0] regs,
    input  logic [IDX_W-1:0]                idx,
    input  logic                            byte_sel,
    output logic [WORD_W-1:0]               data
);
    localparam int BYTE_W = WORD_W / 2;

    logic [WORD_W-1:0] split_src;

    // Select the word or the zero-extended byte.
    always_comb begin
        split_src = regs[{1'b0, idx[IDX_W-2:0]}];
        if (!byte_sel)
            data = regs[idx];
        else if (idx[IDX_W-1])
            data = {{BYTE_W{1'b0}}, split_src[WORD_W-1:BYTE_W]};
        else
            data = {{BYTE_W{1'b0}}, split_src[BYTE_W-1:0]};
    end
endmodule

// File: rtl/gpr_bank.sv
// Top of the general register file: eight registers, two read ports, one
// indexed write port, a 32-bit pair write path, and parallel outputs for
// address logic. Synchronous active-low reset.
module gpr_bank
    import gpr_pkg::*;
#(
    parameter int                WORD_W   = 16,
    parameter logic [WORD_W-1:0] SP_RESET = 16'hFFFE
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          rd_a_idx,
    input  logic                rd_a_byte,
    output logic [WORD_W-1:0]   rd_a_data,
    input  logic [2:0]          rd_b_idx,
    input  logic                rd_b_byte,
    output logic [WORD_W-1:0]   rd_b_data,
    input  logic                wr_en,
    input  logic [2:0]          wr_idx,
    input  logic                wr_byte,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic                pair_wr_en,
    input  logic [2*WORD_W-1:0] pair_wr_data,
    output logic [WORD_W-1:0]   sp_out,
    output logic [WORD_W-1:0]   si_out,
    output logic [WORD_W-1:0]   di_out
);
    localparam int BYTE_W   = WORD_W / 2;
    localparam int RD_PORTS = 2;

    logic [NUM_REGS-1:0][WORD_W-1:0] regs_q;
    logic [NUM_REGS-1:0]             lo_we, hi_we;
    logic [NUM_REGS-1:0][BYTE_W-1:0] lo_d, hi_d;

    logic [RD_PORTS-1:0][IDX_W-1:0]  rd_idx;
    logic [RD_PORTS-1:0]             rd_byte;
    logic [RD_PORTS-1:0][WORD_W-1:0] rd_data;

    gpr_wr_ctrl #(.WORD_W(WORD_W)) u_wr (
        .wr_en        (wr_en),
        .wr_idx       (wr_idx),
        .wr_byte      (wr_byte),
        .wr_data      (wr_data),
        .pair_wr_en   (pair_wr_en),
        .pair_wr_data (pair_wr_data),
        .lo_we        (lo_we),
        .hi_we        (hi_we),
        .lo_d         (lo_d),
        .hi_d         (hi_d)
    );

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_cell
        gpr_cell #(
            .WORD_W     (WORD_W),
            .RST_VAL    ((r == IDX_STK) ? SP_RESET : '0),
            .FORCE_EVEN (r == IDX_STK)
        ) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .lo_we (lo_we[r]),
            .hi_we (hi_we[r]),
            .lo_d  (lo_d[r]),
            .hi_d  (hi_d[r]),
            .q     (regs_q[r])
        );
    end

    // Gather the read-port inputs into arrays for the port generate loop.
    always_comb begin
        rd_idx[0]  = rd_a_idx;
        rd_idx[1]  = rd_b_idx;
        rd_byte[0] = rd_a_byte;
        rd_byte[1] = rd_b_byte;
    end

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
        gpr_rd_port #(.WORD_W(WORD_W)) u_rd (
            .regs     (regs_q),
            .idx      (rd_idx[p]),
            .byte_sel (rd_byte[p]),
            .data     (rd_data[p])
        );
    end

    // Drive the read ports and the parallel address outputs.
    always_comb begin
        rd_a_data = rd_data[0];
        rd_b_data = rd_data[1];
        sp_out    = regs_q[IDX_STK];
        si_out    = regs_q[IDX_SRC];
        di_out    = regs_q[IDX_DST];
    end
endmodule

// File: rtl/gpr_bank_chk.sv
// Assertion checker for gpr_bank, attached through bind. It watches the
// write inputs, the stored registers and the read ports.
module gpr_bank_chk #(
    parameter int WORD_W = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [2:0]              rd_a_idx,
    input logic                    rd_a_byte,
    input logic [WORD_W-1:0]       rd_a_data,
    input logic                    wr_en,
    input logic [2:0]              wr_idx,
    input logic                    wr_byte,
    input logic                    pair_wr_en,
    input logic [2*WORD_W-1:0]     pair_wr_data,
    input logic [WORD_W-1:0]       sp_out,
    input logic [7:0][WORD_W-1:0]  regs_q
);
    localparam int BYTE_W = WORD_W / 2;

    // R8: stack pointer never odd
    a_r8_sp_even: assert property (@(posedge clk) disable iff (!rst_n)
        sp_out[0] == 1'b0);

    // R5: byte read upper bits zero
    a_r5_byte_zext: assert property (@(posedge clk) disable iff (!rst_n)
        rd_a_byte |-> (rd_a_data[WORD_W-1:BYTE_W] == '0));

    // R7: pair write lands on both registers
    a_r7_pair_write: assert property (@(posedge clk) disable iff (!rst_n)
        pair_wr_en |=> (regs_q[0] == $past(pair_wr_data[WORD_W-1:0]))
                    && (regs_q[3] == $past(pair_wr_data[2*WORD_W-1:WORD_W])));

    // R6: byte writes leave the word-only registers alone
    a_r6_word_only_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_byte) |=> (regs_q[4] == $past(regs_q[4]))
                            && (regs_q[5] == $past(regs_q[5]))
                            && (regs_q[6] == $past(regs_q[6]))
                            && (regs_q[7] == $past(regs_q[7])));

    for (genvar g = 0; g < 4; g++) begin : g_half
        // R4: low-byte write keeps the high half
        a_r4_lo_keeps_hi: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_byte && wr_idx == 3'(g) && !pair_wr_en)
            |=> (regs_q[g][WORD_W-1:BYTE_W] == $past(regs_q[g][WORD_W-1:BYTE_W])));
        // R4: high-byte write keeps the low half
        a_r4_hi_keeps_lo: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_byte && wr_idx == 3'(g + 4) && !pair_wr_en)
            |=> (regs_q[g][BYTE_W-1:0] == $past(regs_q[g][BYTE_W-1:0])));
    end
endmodule

bind gpr_bank gpr_bank_chk #(.WORD_W(WORD_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_a_idx     (rd_a_idx),
    .rd_a_byte    (rd_a_byte),
    .rd_a_data    (rd_a_data),
    .wr_en        (wr_en),
    .wr_idx       (wr_idx),
    .wr_byte      (wr_byte),
    .pair_wr_en   (pair_wr_en),
    .pair_wr_data (pair_wr_data),
    .sp_out       (sp_out),
    .regs_q       (regs_q)
);

// File: tb/gpr_bank_tb.sv
`timescale 1ns/1ps
module gpr_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic        rd_a_byte = 1'b0, rd_b_byte = 1'b0, wr_byte = 1'b0;
    logic        wr_en = 1'b0, pair_wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [31:0] pair_wr_data = '0;
    logic [15:0] rd_a_data, rd_b_data, sp_out, si_out, di_out;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    gpr_bank u_dut (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_byte(rd_a_byte), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_byte(rd_b_byte), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_byte(wr_byte), .wr_data(wr_data),
        .pair_wr_en(pair_wr_en), .pair_wr_data(pair_wr_data),
        .sp_out(sp_out), .si_out(si_out), .di_out(di_out)
    );

    // Vector: {wen, wbyte, widx[2:0], wdata[15:0], rbyte, ridx[2:0], exp[15:0]}
    localparam int NVEC = 11;
    localparam logic [40:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 3'd1, 16'h1234, 1'b0, 3'd1, 16'h1234}, // R2 word write BX
        {1'b1, 1'b1, 3'd5, 16'h00AB, 1'b0, 3'd1, 16'hAB34}, // R3 R4 high byte of BX
        {1'b1, 1'b1, 3'd1, 16'h00CD, 1'b0, 3'd1, 16'hABCD}, // R3 R4 low byte of BX
        {1'b0, 1'b0, 3'd0, 16'h0000, 1'b1, 3'd5, 16'h00AB}, // R5 byte read high
        {1'b1, 1'b0, 3'd2, 16'hFFFF, 1'b0, 3'd2, 16'hFFFF}, // R2 word write CX
        {1'b1, 1'b1, 3'd6, 16'h0000, 1'b0, 3'd2, 16'h00FF}, // R4 clear high of CX
        {1'b0, 1'b0, 3'd0, 16'h0000, 1'b1, 3'd2, 16'h00FF}, // R5 byte read low
        {1'b1, 1'b0, 3'd6, 16'h5A5A, 1'b0, 3'd6, 16'h5A5A}, // R2 word write frame reg
        {1'b1, 1'b0, 3'd7, 16'h1235, 1'b0, 3'd7, 16'h1234}, // R8 odd SP write
        {1'b1, 1'b1, 3'd7, 16'h0077, 1'b0, 3'd3, 16'h7700}, // R3 byte idx7 = high of DX
        {1'b0, 1'b0, 3'd0, 16'h0000, 1'b0, 3'd7, 16'h1234}  // R6 SP untouched
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Drive one write at the falling edge and release it after the rising edge.
    task automatic do_write(input logic b, input logic [2:0] i, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_byte = b; wr_idx = i; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    initial begin : watchdog
        #(5.0 * 100000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin : main
        logic [40:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset values on both ports
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            rd_a_idx = 3'(i); rd_b_idx = 3'(i); #1;
            check("R1 port A", rd_a_data, (i == 7) ? 16'hFFFE : 16'h0000);
            check("R1 port B", rd_b_data, (i == 7) ? 16'hFFFE : 16'h0000);
        end
        check("R1 sp_out", sp_out, 16'hFFFE);

        // Vector table walk
        for (int k = 0; k < NVEC; k++) begin
            v = VEC[k];
            @(negedge clk);
            wr_en = v[40]; wr_byte = v[39]; wr_idx = v[38:36]; wr_data = v[35:20];
            rd_a_byte = v[19]; rd_a_idx = v[18:16];
            rd_b_byte = 1'b0;  rd_b_idx = v[18:16];
            @(posedge clk); #1;
            wr_en = 1'b0;
            check($sformatf("R2-vec%0d port A", k), rd_a_data, v[15:0]);
            if (!v[19]) check($sformatf("R2 vec%0d port B", k), rd_b_data, v[15:0]);
        end
        rd_a_byte = 1'b0;

        // R9: same-cycle read returns the old value, new value after edge
        @(negedge clk);
        rd_a_idx = 3'd0;
        wr_en = 1'b1; wr_byte = 1'b0; wr_idx = 3'd0; wr_data = 16'hBEEF; #1;
        check("R9 old value before edge", rd_a_data, 16'h0000);
        @(posedge clk); #1; wr_en = 1'b0;
        check("R9 new value after edge", rd_a_data, 16'hBEEF);

        // R7: pair write plus port write to the source index
        @(negedge clk);
        pair_wr_en = 1'b1; pair_wr_data = 32'h1122_3344;
        wr_en = 1'b1; wr_byte = 1'b0; wr_idx = 3'd4; wr_data = 16'h0404;
        rd_a_idx = 3'd0; rd_b_idx = 3'd3;
        @(posedge clk); #1; wr_en = 1'b0; pair_wr_en = 1'b0;
        check("R7 acc low half", rd_a_data, 16'h3344);
        check("R7 data high half", rd_b_data, 16'h1122);
        check("R7 other port write kept", si_out, 16'h0404);

        // R7: pair write wins over a port write to the data register
        @(negedge clk);
        pair_wr_en = 1'b1; pair_wr_data = 32'hAAAA_5555;
        wr_en = 1'b1; wr_byte = 1'b0; wr_idx = 3'd3; wr_data = 16'h0000;
        @(posedge clk); #1; wr_en = 1'b0; pair_wr_en = 1'b0;
        check("R7 pair wins on data reg", rd_b_data, 16'hAAAA);
        check("R7 acc from pair", rd_a_data, 16'h5555);

        // R10: parallel outputs
        do_write(1'b0, 3'd5, 16'h0D0D);
        check("R10 di_out", di_out, 16'h0D0D);
        check("R10 si_out", si_out, 16'h0404);
        check("R10 sp_out", sp_out, 16'h1234);

        // R6: byte index 4 hits the accumulator high byte, not the source index
        do_write(1'b1, 3'd4, 16'h0099);
        check("R6 source index unchanged", si_out, 16'h0404);
        @(negedge clk); rd_a_idx = 3'd0; #1;
        check("R6 R4 acc high byte written", rd_a_data, 16'h9955);

        // R8: even SP write stored as is
        do_write(1'b0, 3'd7, 16'h8000);
        check("R8 even SP", sp_out, 16'h8000);

        finish_run();
    end
endmodule